// File: doc/BRIEF.md
# Halt Mode Sequencer

This block puts a small microcontroller core into its deepest sleep state and brings it back out. A halt strobe from the instruction decoder is accepted only while the oscillator-interrupt-enable status bit is clear. When accepted, the sequencer turns the main oscillator off. It also gates the CPU and peripheral clock enable and emits a one-cycle request that forces the two interrupt-mask bits to the enabled code. A watchdog option bit can turn a halt attempt into a watchdog reset request instead.

A designated wake interrupt or a reset request ends the halt. The oscillator is switched on at once. A settle counter then holds the CPU clock off for 256 or 4096 cycles. Once the count expires, a one-cycle resume pulse tells the core whether to service the interrupt or fetch the reset vector, and normal running resumes.

Top module: `halt_seq`

## Requirements
- R1: A halt strobe in the running state enters the halted state only when `osc_irq_en` is 0 and the watchdog does not block it (`wdg_en` is 0, or `wdg_halt_ok` is 1).
- R2: On halt entry, `mask_force_vld` is 1 for exactly one cycle, and in that cycle `mask_force` carries 2'b10.
- R3: If an enabled wake interrupt is already asserted when halt is entered, the sequencer leaves the halted state on the next cycle and starts settling.
- R4: While halted, `osc_on` and `cpu_clk_en` are both 0, and they stay 0 until a wake event arrives.
- R5: A wake event (any enabled bit of `wake_irq`, or `wake_rst`) in the halted state sets `osc_on` to 1 in the next cycle, while `cpu_clk_en` stays 0 during settling.
- R6: The settle time is 256 cycles when `long_settle` is 0 and 4096 cycles when it is 1. The value is sampled on the wake cycle only, and later changes have no effect. `resume` appears on the 256th or 4096th cycle after the first settling cycle.
- R7: `resume` is a one-cycle pulse. `resume_irq` is 1 for an interrupt wake and 0 for a reset wake. After the pulse, `cpu_clk_en` and `osc_on` are 1.
- R8: When `wake_rst` and a wake interrupt arrive in the same cycle, the reset takes priority and `resume_irq` is 0.
- R9: A halt strobe with `osc_irq_en`=0, `wdg_en`=1 and `wdg_halt_ok`=0 produces a one-cycle `wdg_rst_req` and no halt. With `wdg_halt_ok`=1, the halt proceeds and no watchdog request is raised.
- R10: A halt strobe while `osc_irq_en` is 1 is ignored: `osc_on` and `cpu_clk_en` stay 1, and `mask_force_vld` and `wdg_rst_req` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (the restarted oscillator during settling) |
| rst_n | input | 1 | Asynchronous active-low system reset |
| halt_req | input | 1 | One-cycle halt instruction strobe |
| osc_irq_en | input | 1 | Oscillator-interrupt-enable status bit; 1 blocks halt |
| wake_irq | input | NUM_WAKE | Wake interrupt requests |
| wake_rst | input | 1 | Reset request that wakes the core |
| wdg_en | input | 1 | Watchdog is running |
| wdg_halt_ok | input | 1 | Option: 1 lets halt proceed with the watchdog running |
| long_settle | input | 1 | Settle-length select: 0 = 256 cycles, 1 = 4096 cycles |
| osc_on | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU and peripheral clock enable |
| mask_force_vld | output | 1 | Pulse: load `mask_force` into the interrupt-mask bits |
| mask_force | output | 2 | Forced interrupt-mask value |
| wdg_rst_req | output | 1 | Pulse: watchdog reset request |
| resume | output | 1 | Pulse: settling done, the core restarts |
| resume_irq | output | 1 | With `resume`: 1 = service interrupt, 0 = fetch reset vector |

## Verification
Random trials vary the status bit, the watchdog enable and its option, the wake cause, the settle length, an early pending interrupt and the idle time spent halted. Together these separate an accepted halt from an ignored strobe and from a watchdog-converted one. The cause patterns (interrupt only, reset only, both together) show whether the resume flag follows the priority rule. Flipping `long_settle` after the wake cycle, and timing both settle lengths exactly, shows whether the length is sampled once and counted exactly.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_RESUME = 2'd3
    } hs_state_e;

    localparam logic [1:0] MASK_ENABLED = 2'b10;
endpackage

// File: rtl/wake_arb.sv
module wake_arb #(
    parameter int                NUM_WAKE = 4,
    parameter logic [NUM_WAKE-1:0] WAKE_EN  = '1
) (
    input  logic [NUM_WAKE-1:0] wake_irq,
    input  logic                wake_rst,
    output logic                wake_any,
    output logic                cause_irq
);
    logic [NUM_WAKE-1:0] gated;

    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_gate
        if (WAKE_EN[g]) begin : g_on
            assign gated[g] = wake_irq[g];
        end else begin : g_off
            assign gated[g] = 1'b0;
        end
    end

    always_comb begin
        wake_any  = wake_rst | (|gated);
        cause_irq = ~wake_rst & (|gated);
    end

    // R8: reset presence always removes the interrupt cause
    always_comb begin
        if (wake_rst) a_rst_prio_r8: assert (!cause_irq);
    end
endmodule

// File: rtl/osc_settle_cnt.sv
module osc_settle_cnt #(
    parameter int SHORT_CYC = 256,
    parameter int LONG_CYC  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(LONG_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cnt = long_sel ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
        end else if (run && r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
        done = (r_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R6: the count never moves while not running or loading
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(r_q.cnt));
endmodule

// File: rtl/halt_seq.sv
module halt_seq
    import halt_seq_pkg::*;
#(
    parameter int                  NUM_WAKE  = 4,
    parameter logic [NUM_WAKE-1:0] WAKE_EN   = '1,
    parameter int                  SHORT_CYC = 256,
    parameter int                  LONG_CYC  = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_req,
    input  logic                osc_irq_en,
    input  logic [NUM_WAKE-1:0] wake_irq,
    input  logic                wake_rst,
    input  logic                wdg_en,
    input  logic                wdg_halt_ok,
    input  logic                long_settle,
    output logic                osc_on,
    output logic                cpu_clk_en,
    output logic                mask_force_vld,
    output logic [1:0]          mask_force,
    output logic                wdg_rst_req,
    output logic                resume,
    output logic                resume_irq
);
    typedef struct packed {
        hs_state_e st;
        logic      cause_irq;
        logic      mask_pulse;
        logic      wdg_pulse;
    } hs_reg_s;

    hs_reg_s r_d, r_q;

    logic wake_any, wake_cause_irq, settle_done;
    logic halt_try, wdg_block, load_cnt;

    wake_arb #(.NUM_WAKE(NUM_WAKE), .WAKE_EN(WAKE_EN)) u_arb (
        .wake_irq (wake_irq),
        .wake_rst (wake_rst),
        .wake_any (wake_any),
        .cause_irq(wake_cause_irq)
    );

    osc_settle_cnt #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_cnt),
        .long_sel(long_settle),
        .run     (r_q.st == ST_SETTLE),
        .done    (settle_done)
    );

    always_comb begin
        r_d            = r_q;
        r_d.mask_pulse = 1'b0;
        r_d.wdg_pulse  = 1'b0;
        halt_try       = halt_req && !osc_irq_en;
        wdg_block      = wdg_en && !wdg_halt_ok;
        load_cnt       = 1'b0;
        unique case (r_q.st)
            ST_RUN: begin
                if (halt_try && wdg_block) begin
                    r_d.wdg_pulse = 1'b1;
                end else if (halt_try) begin
                    r_d.st         = ST_HALT;
                    r_d.mask_pulse = 1'b1;
                end
            end
            ST_HALT: begin
                if (wake_any) begin
                    r_d.st        = ST_SETTLE;
                    r_d.cause_irq = wake_cause_irq;
                    load_cnt      = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle_done) r_d.st = ST_RESUME;
            end
            ST_RESUME: r_d.st = ST_RUN;
            default:   r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN, cause_irq: 1'b0, mask_pulse: 1'b0, wdg_pulse: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        osc_on         = (r_q.st != ST_HALT);
        cpu_clk_en     = (r_q.st == ST_RUN) || (r_q.st == ST_RESUME);
        mask_force_vld = r_q.mask_pulse;
        mask_force     = MASK_ENABLED;
        wdg_rst_req    = r_q.wdg_pulse;
        resume         = (r_q.st == ST_RESUME);
        resume_irq     = r_q.cause_irq;
    end

    p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && halt_req && !osc_irq_en && !(wdg_en && !wdg_halt_ok))
        |=> (r_q.st == ST_HALT));

    p_mask_at_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_force_vld |-> (r_q.st == ST_HALT && $past(r_q.st) == ST_RUN));

    p_pending_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HALT && |(wake_irq & WAKE_EN)) |=> (r_q.st == ST_SETTLE));

    p_halt_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HALT && !wake_any) |=> (!osc_on && !cpu_clk_en));

    p_osc_on_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HALT && wake_any) |=> (osc_on && !cpu_clk_en));

    p_resume_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (!resume && cpu_clk_en && osc_on));

    p_rst_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HALT && wake_rst) |=> !resume_irq);

    p_wdg_convert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && halt_req && !osc_irq_en && wdg_en && !wdg_halt_ok)
        |=> (wdg_rst_req && r_q.st == ST_RUN));

    p_oie_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && halt_req && osc_irq_en) |=> (r_q.st == ST_RUN && !mask_force_vld));
endmodule

// File: tb/halt_seq_test.sv
module halt_seq_test;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 0, osc_irq_en = 0, wake_rst = 0, wdg_en = 0, wdg_halt_ok = 0, long_settle = 0;
    logic [NW-1:0] wake_irq = '0;
    logic osc_on, cpu_clk_en, mask_force_vld, wdg_rst_req, resume, resume_irq;
    logic [1:0] mask_force;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    halt_seq #(.NUM_WAKE(NW)) uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_irq_en(osc_irq_en),
        .wake_irq(wake_irq), .wake_rst(wake_rst), .wdg_en(wdg_en),
        .wdg_halt_ok(wdg_halt_ok), .long_settle(long_settle), .osc_on(osc_on),
        .cpu_clk_en(cpu_clk_en), .mask_force_vld(mask_force_vld),
        .mask_force(mask_force), .wdg_rst_req(wdg_rst_req), .resume(resume),
        .resume_irq(resume_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_enter(bit oie, bit wen, bit wok);
        return !oie && !(wen && !wok);
    endfunction

    function automatic bit exp_wdg(bit oie, bit wen, bit wok);
        return !oie && wen && !wok;
    endfunction

    function automatic int exp_settle(bit lng);
        return lng ? 4096 : 256;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic trial(input bit oie, input bit wen, input bit wok, input bit pend,
                         input bit by_irq, input bit by_rst, input bit lng, input int idle);
        bit ent;
        bit wd;
        int n;
        @(negedge clk);
        halt_req = 1; osc_irq_en = oie; wdg_en = wen; wdg_halt_ok = wok;
        if (pend) wake_irq = NW'(1) << $urandom_range(NW-1);
        ent = exp_enter(oie, wen, wok);
        wd  = exp_wdg(oie, wen, wok);
        @(negedge clk);
        halt_req = 0;
        chk("R9 wdg_rst_req", int'(wdg_rst_req), int'(wd));
        chk("R2 mask_force_vld", int'(mask_force_vld), int'(ent));
        if (ent) chk("R2 mask_force", int'(mask_force), 2);
        chk(oie ? "R10 osc_on" : "R1 osc_on", int'(osc_on), int'(!ent));
        if (oie) chk("R10 cpu_clk_en", int'(cpu_clk_en), 1);
        if (!ent) begin
            wake_irq = '0;
            @(negedge clk);
            chk("R9 wdg pulse single", int'(wdg_rst_req), 0);
            chk("R2 mask pulse single", int'(mask_force_vld), 0);
            return;
        end
        if (!pend) begin
            for (int i = 0; i < idle; i++) begin
                @(negedge clk);
                chk("R4 halted osc_on", int'(osc_on), 0);
                chk("R4 halted cpu_clk_en", int'(cpu_clk_en), 0);
            end
            long_settle = lng;
            wake_irq = by_irq ? (NW'(1) << $urandom_range(NW-1)) : '0;
            wake_rst = by_rst;
        end else begin
            long_settle = lng;
            wake_rst = by_rst;
            by_irq = 1;
        end
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                wake_irq = '0;
                wake_rst = 0;
                long_settle = !lng;
                chk(pend ? "R3 pending wake osc_on" : "R5 osc_on", int'(osc_on), 1);
                chk("R5 cpu_clk_en held", int'(cpu_clk_en), 0);
            end
            if (resume) break;
        end
        chk("R6 settle cycles", n, exp_settle(lng) + 1);
        chk(by_rst && by_irq ? "R8 reset priority" : "R7 resume_irq", int'(resume_irq),
            int'(by_irq && !by_rst));
        @(negedge clk);
        chk("R7 resume single", int'(resume), 0);
        chk("R7 cpu_clk_en after", int'(cpu_clk_en), 1);
        long_settle = 0;
    endtask

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        chk("R4 reset osc_on", int'(osc_on), 1);
        chk("R7 reset cpu_clk_en", int'(cpu_clk_en), 1);
        chk("R7 reset resume", int'(resume), 0);
        chk("R9 reset wdg", int'(wdg_rst_req), 0);
        rst_n = 1;
        @(negedge clk);
        // directed corners
        trial(1, 0, 0, 0, 1, 0, 0, 2);   // R10 ignored strobe
        trial(0, 1, 0, 0, 1, 0, 0, 2);   // R9 converted to watchdog reset
        trial(0, 1, 1, 0, 1, 0, 0, 2);   // R9 option lets halt proceed
        trial(0, 0, 0, 1, 1, 0, 0, 0);   // R3 pending interrupt
        trial(0, 0, 0, 0, 1, 1, 0, 3);   // R8 same-cycle reset and interrupt
        trial(0, 0, 0, 0, 0, 1, 1, 1);   // R6 long settle, reset cause
        trial(0, 0, 0, 0, 1, 0, 1, 4);   // R6 long settle, interrupt cause
        for (int t = 0; t < 30; t++) begin
            bit rirq, rrst;
            rirq = 1'($urandom_range(1));
            rrst = 1'($urandom_range(1));
            if (!rirq && !rrst) rirq = 1;
            trial(1'($urandom_range(3) == 0), 1'($urandom_range(1)), 1'($urandom_range(1)),
                  1'($urandom_range(3) == 0), rirq, rrst,
                  1'($urandom_range(7) == 0), $urandom_range(5));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule